// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a 32-bit core whose instructions are all four bytes wide, and works out the address of the next instruction. Each cycle it is given the class of the instruction being retired: sequential, branch-if-equal, branch-if-different, direct jump, direct jump with link, or jump through a register. With that class it gets the 16-bit branch offset, the 26-bit jump field, a register operand for indirect jumps, and the two register values to compare. It drives the next address combinationally. On every clock edge with the advance enable high, the PC register takes that address.

For a call, the block presents the return address (the current PC plus four) and the index of the link register, with a write strobe for the register file. A jump through a register always lands on a word boundary. If the operand's two low bits were not zero, a separate flag is raised so that the core can trap. All pins are plain control and data pins with no handshake. Back-pressure is expressed only by holding the advance enable low, which freezes the PC.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) loads pc_q with the reset vector, default 0x0000_1000, with its two low bits forced to zero. Reset takes priority over step_en.
- R2: While step_en is low and rst is low, pc_q keeps its value across clock edges, and link_we stays low.
- R3: For flow_kind 0 (sequential), pc_next equals pc_q + 4. With step_en high, pc_q takes that value at the next edge.
- R4: For flow_kind 1 (branch if equal), pc_next is (pc_q + 4) + (sign-extended br_imm × 4) when cmp_a equals cmp_b, and pc_q + 4 otherwise.
- R5: For flow_kind 2 (branch if different), pc_next is the same branch target when cmp_a differs from cmp_b, and pc_q + 4 otherwise.
- R6: For flow_kind 3 (direct jump), pc_next is {(pc_q+4)[31:28], jmp_field, 2'b00}. The region bits come from the incremented PC.
- R7: For flow_kind 4 (jump with link), pc_next is the same as in R6. link_addr equals pc_q + 4, link_dest is 31, and link_we is high when step_en is high.
- R8: For flow_kind 5 (jump through register), pc_next is {ind_target[31:2], 2'b00}. ind_misalign is high exactly when flow_kind is 5 and ind_target[1:0] is not zero.
- R9: link_we is low for every flow_kind other than 4. Codes 6 and 7 behave as sequential.
- R10: Address arithmetic wraps modulo 2^32, so pc_q 0xFFFF_FFFC advances sequentially to 0x0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance enable; low holds the PC |
| flow_kind | input | 3 | Instruction class: 0 seq, 1 branch equal, 2 branch different, 3 jump, 4 jump with link, 5 jump through register |
| br_imm | input | 16 | Signed word offset for branches |
| jmp_field | input | 26 | Word target field for direct jumps |
| ind_target | input | 32 | Register operand for indirect jumps |
| cmp_a | input | 32 | First compared register value |
| cmp_b | input | 32 | Second compared register value |
| pc_q | output | 32 | Current program counter |
| pc_next | output | 32 | Address the PC takes on the next enabled edge |
| link_addr | output | 32 | Return address, pc_q + 4 |
| link_dest | output | 5 | Index of the link register (31) |
| link_we | output | 1 | Link register write strobe |
| ind_misalign | output | 1 | Indirect target had non-zero low bits |

## Verification
The assertions check the following on every cycle:
- reset loads the vector;
- the PC is frozen while step_en is low;
- a sequential step adds four;
- a direct jump keeps the region bits of the incremented PC;
- the link strobe appears only for a call, and the return address it carries is correct;
- the misalignment flag appears only for register jumps.

Only the bench scenarios can show the following:
- the taken and not-taken branch decisions for both compare senses;
- sign extension of a large negative offset;
- the masking of register targets;
- wrap-around at the top of the address space;
- a jump whose region bits differ between the PC and the PC plus four.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [2:0] {
    FLOW_SEQ  = 3'd0,
    FLOW_BEQ  = 3'd1,
    FLOW_BNE  = 3'd2,
    FLOW_JMP  = 3'd3,
    FLOW_JAL  = 3'd4,
    FLOW_JREG = 3'd5
  } flow_kind_e;

  localparam int unsigned LINK_IDX_W = 5;
  localparam logic [LINK_IDX_W-1:0] LINK_REG_IDX = 5'd31;

endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_cur,
  output logic [XLEN-1:0] pc_plus
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  // modulo 2^XLEN by width
  assign pc_plus = pc_cur + STEP;
endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned BR_W  = 16,
  parameter int unsigned JMP_W = 26
) (
  input  logic [XLEN-1:0]  pc_plus,
  input  logic [BR_W-1:0]  br_imm,
  input  logic [JMP_W-1:0] jmp_field,
  input  logic [XLEN-1:0]  ind_target,
  output logic [XLEN-1:0]  br_tgt,
  output logic [XLEN-1:0]  jmp_tgt,
  output logic [XLEN-1:0]  ind_tgt,
  output logic             ind_bad
);
  localparam int unsigned SHIFT    = 2;
  localparam int unsigned EXT_W    = XLEN - BR_W - SHIFT;
  localparam int unsigned REGION_W = XLEN - JMP_W - SHIFT;

  logic [XLEN-1:0] br_off;

  // sign-extended word offset turned into bytes
  assign br_off = {{EXT_W{br_imm[BR_W-1]}}, br_imm, {SHIFT{1'b0}}};
  assign br_tgt = pc_plus + br_off;

  generate
    if (REGION_W > 0) begin : g_region
      assign jmp_tgt = {pc_plus[XLEN-1 -: REGION_W], jmp_field, {SHIFT{1'b0}}};
    end else begin : g_flat
      assign jmp_tgt = {jmp_field, {SHIFT{1'b0}}};
    end
  endgenerate

  assign ind_tgt = {ind_target[XLEN-1:SHIFT], {SHIFT{1'b0}}};
  assign ind_bad = |ind_target[SHIFT-1:0];
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  flow_kind_e       flow,
  input  logic             step_en,
  input  logic [XLEN-1:0]  cmp_a,
  input  logic [XLEN-1:0]  cmp_b,
  input  logic [XLEN-1:0]  pc_plus,
  input  logic [XLEN-1:0]  br_tgt,
  input  logic [XLEN-1:0]  jmp_tgt,
  input  logic [XLEN-1:0]  ind_tgt,
  input  logic             ind_bad,
  output logic [XLEN-1:0]  pc_next,
  output logic             link_we,
  output logic             misalign
);
  logic same;
  assign same = (cmp_a == cmp_b);

  always_comb begin
    pc_next  = pc_plus;
    link_we  = 1'b0;
    misalign = 1'b0;
    case (flow)
      FLOW_BEQ:  if (same)  pc_next = br_tgt;
      FLOW_BNE:  if (!same) pc_next = br_tgt;
      FLOW_JMP:  pc_next = jmp_tgt;
      FLOW_JAL: begin
        pc_next = jmp_tgt;
        link_we = step_en;
      end
      FLOW_JREG: begin
        pc_next  = ind_tgt;
        misalign = ind_bad;
      end
      default:   pc_next = pc_plus;
    endcase
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import npc_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned BR_W      = 16,
  parameter int unsigned JMP_W     = 26,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step_en,
  input  logic [2:0]            flow_kind,
  input  logic [BR_W-1:0]       br_imm,
  input  logic [JMP_W-1:0]      jmp_field,
  input  logic [XLEN-1:0]       ind_target,
  input  logic [XLEN-1:0]       cmp_a,
  input  logic [XLEN-1:0]       cmp_b,
  output logic [XLEN-1:0]       pc_q,
  output logic [XLEN-1:0]       pc_next,
  output logic [XLEN-1:0]       link_addr,
  output logic [LINK_IDX_W-1:0] link_dest,
  output logic                  link_we,
  output logic                  ind_misalign
);
  localparam int unsigned   REGION_W  = XLEN - JMP_W - 2;
  localparam logic [XLEN-1:0] RST_ALIGN = XLEN'(RESET_VEC) & ~XLEN'(3);

  flow_kind_e      flow;
  logic [XLEN-1:0] pc_plus, br_tgt, jmp_tgt, ind_tgt;
  logic            ind_bad;

  assign flow = flow_kind_e'(flow_kind);

  npc_incr #(.XLEN(XLEN), .INSN_BYTES(4)) u_incr (
    .pc_cur (pc_q),
    .pc_plus(pc_plus)
  );

  npc_targets #(.XLEN(XLEN), .BR_W(BR_W), .JMP_W(JMP_W)) u_tgt (
    .pc_plus   (pc_plus),
    .br_imm    (br_imm),
    .jmp_field (jmp_field),
    .ind_target(ind_target),
    .br_tgt    (br_tgt),
    .jmp_tgt   (jmp_tgt),
    .ind_tgt   (ind_tgt),
    .ind_bad   (ind_bad)
  );

  npc_select #(.XLEN(XLEN)) u_sel (
    .flow    (flow),
    .step_en (step_en),
    .cmp_a   (cmp_a),
    .cmp_b   (cmp_b),
    .pc_plus (pc_plus),
    .br_tgt  (br_tgt),
    .jmp_tgt (jmp_tgt),
    .ind_tgt (ind_tgt),
    .ind_bad (ind_bad),
    .pc_next (pc_next),
    .link_we (link_we),
    .misalign(ind_misalign)
  );

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= RST_ALIGN;
    else if (step_en) pc_q <= pc_next;
  end

  assign link_addr = pc_plus;
  assign link_dest = LINK_REG_IDX;

  // R1
  reset_vec_chk: assert property (@(posedge clk)
    rst |=> pc_q == RST_ALIGN);

  // R2
  hold_pc_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(pc_q));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && flow_kind == 3'd0) |=> pc_q == $past(pc_q) + 32'd4);

  // R6
  jmp_region_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && flow_kind == 3'd3) |=>
      (pc_q[XLEN-1 -: REGION_W] == $past(pc_plus[XLEN-1 -: REGION_W]) && pc_q[1:0] == 2'b00));

  // R7
  link_addr_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_addr == pc_q + 32'd4 && link_dest == 5'd31));

  // R9
  link_only_call_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (flow_kind == 3'd4 && step_en));

  // R8
  misalign_only_jreg_chk: assert property (@(posedge clk) disable iff (rst)
    ind_misalign |-> flow_kind == 3'd5);
endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;

  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] imm;
    logic [25:0] jf;
    logic [31:0] ind;
    logic [31:0] a;
    logic [31:0] b;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'h0000, 26'h0,       32'h0,         32'h0, 32'h0},  // R3
    '{3'd1, 16'h0003, 26'h0,       32'h0,         32'h5, 32'h5},  // R4 taken
    '{3'd1, 16'h0003, 26'h0,       32'h0,         32'h5, 32'h6},  // R4 not taken
    '{3'd2, 16'hFFFE, 26'h0,       32'h0,         32'h1, 32'h2},  // R5 taken back
    '{3'd2, 16'h0010, 26'h0,       32'h0,         32'h7, 32'h7},  // R5 not taken
    '{3'd3, 16'h0000, 26'h0000100, 32'h0,         32'h0, 32'h0},  // R6
    '{3'd4, 16'h0000, 26'h0000200, 32'h0,         32'h0, 32'h0},  // R7
    '{3'd5, 16'h0000, 26'h0,       32'h2000_0003, 32'h0, 32'h0},  // R8 misaligned
    '{3'd3, 16'h0000, 26'h3FFFFFF, 32'h0,         32'h0, 32'h0},  // R6 region 2
    '{3'd0, 16'h0000, 26'h0,       32'h0,         32'h0, 32'h0},  // R3
    '{3'd1, 16'h8000, 26'h0,       32'h0,         32'h9, 32'h9},  // R4 most negative
    '{3'd6, 16'h0040, 26'h1234,    32'h0,         32'h0, 32'h0},  // R9 unused code
    '{3'd5, 16'h0000, 26'h0,       32'hFFFF_FFFC, 32'h0, 32'h0},  // R8 aligned
    '{3'd0, 16'h0000, 26'h0,       32'h0,         32'h0, 32'h0},  // R10 wrap
    '{3'd5, 16'h0000, 26'h0,       32'h0FFF_FFFE, 32'h0, 32'h0},  // R8
    '{3'd3, 16'h0000, 26'h0000000, 32'h0,         32'h0, 32'h0},  // R6 region from pc+4
    '{3'd7, 16'h0000, 26'h0,       32'h0,         32'h3, 32'h3}   // R9 unused code
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0;
  logic [2:0]  flow_kind = 3'd0;
  logic [15:0] br_imm = '0;
  logic [25:0] jmp_field = '0;
  logic [31:0] ind_target = '0, cmp_a = '0, cmp_b = '0;
  logic [31:0] pc_q, pc_next, link_addr;
  logic [4:0]  link_dest;
  logic        link_we, ind_misalign;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_pc;

  always #4 clk = ~clk;

  pc_sequencer u_dut (
    .clk(clk), .rst(rst), .step_en(step_en), .flow_kind(flow_kind),
    .br_imm(br_imm), .jmp_field(jmp_field), .ind_target(ind_target),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .pc_q(pc_q), .pc_next(pc_next),
    .link_addr(link_addr), .link_dest(link_dest), .link_we(link_we),
    .ind_misalign(ind_misalign)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] pc, input vec_t v);
    logic [31:0] p4, bt;
    p4 = pc + 32'd4;
    bt = p4 + {{14{v.imm[15]}}, v.imm, 2'b00};
    case (v.kind)
      3'd1: return (v.a == v.b) ? bt : p4;
      3'd2: return (v.a != v.b) ? bt : p4;
      3'd3, 3'd4: return {p4[31:28], v.jf, 2'b00};
      3'd5: return {v.ind[31:2], 2'b00};
      default: return p4;
    endcase
  endfunction

  task automatic apply(input vec_t v);
    flow_kind = v.kind; br_imm = v.imm; jmp_field = v.jf;
    ind_target = v.ind; cmp_a = v.a; cmp_b = v.b;
  endtask

  initial begin
    #150000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset vector", pc_q, 32'h0000_1000);
    rst = 1'b0;
    exp_pc = 32'h0000_1000;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      step_en = 1'b1;
      #1;
      check("R3-R10 pc_next", pc_next, model_next(exp_pc, VECS[i]));
      check("R7 link_addr", link_addr, exp_pc + 32'd4);
      check("R7/R9 link_we", {31'd0, link_we}, {31'd0, VECS[i].kind == 3'd4});
      check("R8 ind_misalign", {31'd0, ind_misalign},
            {31'd0, (VECS[i].kind == 3'd5) && (VECS[i].ind[1:0] != 2'b00)});
      if (VECS[i].kind == 3'd4) check("R7 link_dest", {27'd0, link_dest}, 32'd31);
      exp_pc = model_next(exp_pc, VECS[i]);
      @(posedge clk); #1;
      check("R3-R10 pc_q", pc_q, exp_pc);
    end

    // R10: explicit wrap from the top of the address space
    @(negedge clk);
    apply('{3'd5, 16'h0, 26'h0, 32'hFFFF_FFFC, 32'h0, 32'h0});
    @(posedge clk); #1;
    @(negedge clk);
    apply('{3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 32'h0});
    @(posedge clk); #1;
    check("R10 wrap", pc_q, 32'h0000_0000);

    // R2: disabled step with a call pending changes nothing
    @(negedge clk);
    exp_pc = pc_q;
    apply('{3'd4, 16'h0, 26'h0001234, 32'h0, 32'h0, 32'h0});
    step_en = 1'b0;
    #1;
    check("R2 link_we held low", {31'd0, link_we}, 32'd0);
    repeat (3) @(posedge clk);
    #1;
    check("R2 pc held", pc_q, exp_pc);

    // R1: reset mid-run beats step_en
    @(negedge clk);
    step_en = 1'b1;
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset priority", pc_q, 32'h0000_1000);
    @(negedge clk);
    rst = 1'b0;
    apply('{3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 32'h0});
    @(posedge clk); #1;
    check("R3 step after reset", pc_q, 32'h0000_1004);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule